// File: doc/BRIEF.md
# SDRAM Bank-State Command Encoder

This block sits between a memory scheduler and the command pins of a four-bank SDRAM device. The scheduler presents one request at a time: open a row, write to a column, close one bank, or close all banks. It also gives a bank number, an address and an auto-close flag. The block keeps track of which banks hold an open row. When a request is legal for the current bank state, the block encodes it onto the row-strobe, column-strobe and write-enable pins, the bank-select bits and the address bus. When it is illegal, the block drives an idle command instead and raises a one-cycle error pulse.

The block also counts, for each bank, how many cycles its row has been open. It flags a bank whose open time exceeds the `TRAS_MAX_CYCLES` parameter, so the scheduler can close that bank.

The acceptance indication is combinational from the request and the current bank state. The pin command, the bank bits, the address and the error pulse appear on registered outputs one clock after the request is presented.

Top module: `sdram_bank_cmd_enc`

## Requirements
- R1: After reset, the pins carry the idle command (ras_n, cas_n and we_n all 1, bank bits and address 0). No bank is open, `req_error` is 0 and no overrun flag is set.
- R2: An accepted open-row request (`req_op` = 2'b00) drives ras_n=0, cas_n=1, we_n=1 one cycle later. The bank bits equal `req_bank` and the address equals `req_addr`. That bank then reads as open.
- R3: An accepted write (`req_op` = 2'b01) drives ras_n=1, cas_n=0, we_n=0 one cycle later. The bank bits equal `req_bank`. Address bits 8..0 equal `req_addr[8:0]`, bit 10 equals `req_autopre`, and bits 9 and 11 are 0.
- R4: A single-bank close (`req_op` = 2'b10) is always accepted. It drives ras_n=0, cas_n=1, we_n=0, with the bank bits equal to `req_bank` and an all-zero address (bit 10 low). It leaves that bank closed and the other banks unchanged.
- R5: A close-all request (`req_op` = 2'b11) is always accepted. It drives ras_n=0, cas_n=1, we_n=0, with address bit 10 high, all other address bits 0 and bank bits 0, whatever `req_bank` is. All banks are then closed.
- R6: A write to a closed bank is rejected. The pins show the idle command with zero bank bits and address, `req_error` is 1 for exactly that one cycle, and the bank states are unchanged.
- R7: An open-row request to a bank that is already open is rejected in the same way as R6, and that bank's open-time count keeps running.
- R8: `req_ready` is 1 exactly when `req_valid` is 1 and the request is legal for the bank states held at that moment.
- R9: In any cycle after one with `req_valid` low, the pins carry the idle command and `req_error` is 0.
- R10: An accepted write with `req_autopre` = 1 leaves its bank closed from the next cycle on.
- R11: A bank's count is 0 on the edge that opens it and rises by one each later edge while the bank stays open. `tras_violation[bank]` is 1 while the bank is open and its count is greater than `TRAS_MAX_CYCLES`.
- R12: Closing a bank, by single close, close-all or an auto-close write, clears its overrun flag from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is present |
| req_op | input | 2 | 00 open row, 01 write, 10 close one bank, 11 close all |
| req_bank | input | 2 | Target bank |
| req_addr | input | 12 | Row address (open) or column in bits 8..0 (write) |
| req_autopre | input | 1 | Close the bank after this write |
| req_ready | output | 1 | Request legal and taken this cycle |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank-select bits |
| sd_addr | output | 12 | Address bus |
| req_error | output | 1 | One-cycle pulse for a rejected request |
| bank_active | output | 4 | Per-bank open state |
| tras_violation | output | 4 | Per-bank open-time overrun flag |

## Verification
The assertions assume that `req_op`, `req_bank` and the other request fields are at known values whenever `req_valid` is high. They also assume that reset is held for at least one edge before any request is presented. The stimulus drives all request fields at every negative edge, including cycles where `req_valid` is low, so no field is ever unknown. It releases reset only after several edges. Illegal requests are mixed in on purpose, because the rejection path is part of the defined behaviour and not something outside the assumptions.

// File: rtl/sdram_cmd_pkg.sv
package sdram_cmd_pkg;

    typedef enum logic [1:0] {
        OP_OPEN    = 2'b00,
        OP_WRITE   = 2'b01,
        OP_CLOSE   = 2'b10,
        OP_CLOSE_A = 2'b11
    } req_op_e;

    // Pin triple ordered {ras_n, cas_n, we_n}
    localparam logic [2:0] PINS_IDLE  = 3'b111;
    localparam logic [2:0] PINS_OPEN  = 3'b011;
    localparam logic [2:0] PINS_WRITE = 3'b100;
    localparam logic [2:0] PINS_CLOSE = 3'b010;

endpackage

// File: rtl/sdram_req_check.sv
module sdram_req_check
    import sdram_cmd_pkg::*;
#(
    parameter int BANK_W = 2,
    localparam int NUM_BANKS = 1 << BANK_W
) (
    input  logic                 req_valid,
    input  logic [1:0]           req_op,
    input  logic [BANK_W-1:0]    req_bank,
    input  logic [NUM_BANKS-1:0] bank_open,
    output logic                 accept,
    output logic                 reject
);

    logic legal;

    always_comb begin
        unique case (req_op_e'(req_op))
            OP_OPEN:    legal = !bank_open[req_bank];
            OP_WRITE:   legal = bank_open[req_bank];
            OP_CLOSE:   legal = 1'b1;
            OP_CLOSE_A: legal = 1'b1;
            default:    legal = 1'b0;
        endcase
        accept = req_valid && legal;
        reject = req_valid && !legal;
    end

endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
    import sdram_cmd_pkg::*;
#(
    parameter int BANK_W          = 2,
    parameter int TRAS_MAX_CYCLES = 16,
    localparam int NUM_BANKS = 1 << BANK_W,
    localparam int CNT_W     = $clog2(TRAS_MAX_CYCLES + 2)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 accept,
    input  logic [1:0]           req_op,
    input  logic [BANK_W-1:0]    req_bank,
    input  logic                 req_autopre,
    output logic [NUM_BANKS-1:0] bank_open,
    output logic [NUM_BANKS-1:0] overrun
);

    localparam logic [CNT_W-1:0] CNT_LIMIT = CNT_W'(TRAS_MAX_CYCLES);
    localparam logic [CNT_W-1:0] CNT_SAT   = CNT_W'(TRAS_MAX_CYCLES + 1);

    typedef struct packed {
        logic [NUM_BANKS-1:0]            open;
        logic [NUM_BANKS-1:0][CNT_W-1:0] cnt;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d = trk_q;
        for (int b = 0; b < NUM_BANKS; b++) begin
            logic hit;
            hit = (req_bank == BANK_W'(b));
            if (trk_q.open[b] && trk_q.cnt[b] != CNT_SAT)
                trk_d.cnt[b] = trk_q.cnt[b] + 1'b1;
            if (accept) begin
                unique case (req_op_e'(req_op))
                    OP_OPEN: if (hit) begin
                        trk_d.open[b] = 1'b1;
                        trk_d.cnt[b]  = '0;
                    end
                    OP_WRITE: if (hit && req_autopre) begin
                        trk_d.open[b] = 1'b0;
                        trk_d.cnt[b]  = '0;
                    end
                    OP_CLOSE: if (hit) begin
                        trk_d.open[b] = 1'b0;
                        trk_d.cnt[b]  = '0;
                    end
                    OP_CLOSE_A: begin
                        trk_d.open[b] = 1'b0;
                        trk_d.cnt[b]  = '0;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    assign bank_open = trk_q.open;

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_ovr
        assign overrun[g] = trk_q.open[g] && (trk_q.cnt[g] > CNT_LIMIT);

        AST_OVERRUN_NEEDS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
            overrun[g] |-> $past(trk_q.open[g])) else $error("overrun on closed bank"); // R11
    end

    AST_OPEN_SETS_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_op == OP_OPEN) |=> bank_open[$past(req_bank)]) else $error("open lost"); // R2

    AST_CLOSE_ALL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_op == OP_CLOSE_A) |=> (bank_open == '0 && overrun == '0)) else $error("close-all"); // R5

    AST_AUTOPRE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_op == OP_WRITE && req_autopre) |=> !bank_open[$past(req_bank)]) else $error("autopre"); // R10

endmodule

// File: rtl/sdram_pin_encoder.sv
module sdram_pin_encoder
    import sdram_cmd_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int ADDR_W = 12,
    parameter int COL_W  = 9,
    parameter int AP_BIT = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              reject,
    input  logic [1:0]        req_op,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_autopre,
    output logic [2:0]        pins,
    output logic [BANK_W-1:0] ba,
    output logic [ADDR_W-1:0] addr,
    output logic              err
);

    typedef struct packed {
        logic [2:0]        pins;
        logic [BANK_W-1:0] ba;
        logic [ADDR_W-1:0] addr;
        logic              err;
    } enc_t;

    localparam enc_t ENC_RESET = '{pins: PINS_IDLE, ba: '0, addr: '0, err: 1'b0};

    enc_t enc_d, enc_q;

    always_comb begin
        enc_d     = ENC_RESET;
        enc_d.err = reject;
        if (accept) begin
            unique case (req_op_e'(req_op))
                OP_OPEN: begin
                    enc_d.pins = PINS_OPEN;
                    enc_d.ba   = req_bank;
                    enc_d.addr = req_addr;
                end
                OP_WRITE: begin
                    enc_d.pins              = PINS_WRITE;
                    enc_d.ba                = req_bank;
                    enc_d.addr[COL_W-1:0]   = req_addr[COL_W-1:0];
                    enc_d.addr[AP_BIT]      = req_autopre;
                end
                OP_CLOSE: begin
                    enc_d.pins = PINS_CLOSE;
                    enc_d.ba   = req_bank;
                end
                OP_CLOSE_A: begin
                    enc_d.pins         = PINS_CLOSE;
                    enc_d.addr[AP_BIT] = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) enc_q <= ENC_RESET;
        else        enc_q <= enc_d;
    end

    assign pins = enc_q.pins;
    assign ba   = enc_q.ba;
    assign addr = enc_q.addr;
    assign err  = enc_q.err;

    AST_IDLE_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !(accept || reject) |=> (pins == PINS_IDLE && !err)) else $error("idle"); // R9

    AST_ERROR_IS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (reject && !$past(reject)) |=> err) else $error("err pulse"); // R6

    AST_CLOSE_ALL_A10: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_op == OP_CLOSE_A) |=> (addr[AP_BIT] && ba == '0)) else $error("a10"); // R5

endmodule

// File: rtl/sdram_bank_cmd_enc.sv
module sdram_bank_cmd_enc
    import sdram_cmd_pkg::*;
#(
    parameter int BANK_W          = 2,
    parameter int ADDR_W          = 12,
    parameter int COL_W           = 9,
    parameter int AP_BIT          = 10,
    parameter int TRAS_MAX_CYCLES = 16,
    localparam int NUM_BANKS = 1 << BANK_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [1:0]           req_op,
    input  logic [BANK_W-1:0]    req_bank,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic                 req_autopre,
    output logic                 req_ready,
    output logic                 sd_ras_n,
    output logic                 sd_cas_n,
    output logic                 sd_we_n,
    output logic [BANK_W-1:0]    sd_ba,
    output logic [ADDR_W-1:0]    sd_addr,
    output logic                 req_error,
    output logic [NUM_BANKS-1:0] bank_active,
    output logic [NUM_BANKS-1:0] tras_violation
);

    logic       accept;
    logic       reject;
    logic [2:0] pins;

    sdram_req_check #(.BANK_W(BANK_W)) u_check (
        .req_valid (req_valid),
        .req_op    (req_op),
        .req_bank  (req_bank),
        .bank_open (bank_active),
        .accept    (accept),
        .reject    (reject)
    );

    sdram_bank_tracker #(.BANK_W(BANK_W), .TRAS_MAX_CYCLES(TRAS_MAX_CYCLES)) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept      (accept),
        .req_op      (req_op),
        .req_bank    (req_bank),
        .req_autopre (req_autopre),
        .bank_open   (bank_active),
        .overrun     (tras_violation)
    );

    sdram_pin_encoder #(.BANK_W(BANK_W), .ADDR_W(ADDR_W), .COL_W(COL_W), .AP_BIT(AP_BIT)) u_enc (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept      (accept),
        .reject      (reject),
        .req_op      (req_op),
        .req_bank    (req_bank),
        .req_addr    (req_addr),
        .req_autopre (req_autopre),
        .pins        (pins),
        .ba          (sd_ba),
        .addr        (sd_addr),
        .err         (req_error)
    );

    assign req_ready = accept;
    assign {sd_ras_n, sd_cas_n, sd_we_n} = pins;

    AST_ERROR_MEANS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_error |-> (sd_ras_n && sd_cas_n && sd_we_n)) else $error("err not idle"); // R6

    AST_WRITE_NEEDS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_op == OP_WRITE) |-> bank_active[req_bank]) else $error("write closed"); // R6

    AST_REOPEN_REJECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == OP_OPEN && bank_active[req_bank]) |=> req_error) else $error("reopen"); // R7

    AST_READY_NO_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> !req_error) else $error("ready err"); // R8

endmodule

// File: tb/tb_sdram_bank_cmd_enc.sv
module tb_sdram_bank_cmd_enc;

    localparam int TMAX = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'b00;
    logic [1:0]  req_bank = 2'b00;
    logic [11:0] req_addr = '0;
    logic        req_autopre = 1'b0;
    logic        req_ready, sd_ras_n, sd_cas_n, sd_we_n, req_error;
    logic [1:0]  sd_ba;
    logic [11:0] sd_addr;
    logic [3:0]  bank_active, tras_violation;

    int checks = 0;
    int errors = 0;

    // Reference model state
    bit [3:0]    m_open;
    int          m_cnt [4];
    bit [2:0]    m_pins;
    bit [1:0]    m_ba;
    bit [11:0]   m_addr;
    bit          m_err;

    always #4 clk = ~clk;

    sdram_bank_cmd_enc #(.TRAS_MAX_CYCLES(TMAX)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_bank(req_bank), .req_addr(req_addr), .req_autopre(req_autopre),
        .req_ready(req_ready), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
        .sd_ba(sd_ba), .sd_addr(sd_addr), .req_error(req_error),
        .bank_active(bank_active), .tras_violation(tras_violation)
    );

    function automatic bit m_legal(bit v, bit [1:0] op, bit [1:0] b);
        if (!v) return 1'b0;
        if (op == 2'b00) return !m_open[b];
        if (op == 2'b01) return m_open[b];
        return 1'b1;
    endfunction

    function automatic bit [3:0] m_viol();
        bit [3:0] r;
        for (int i = 0; i < 4; i++) r[i] = m_open[i] && (m_cnt[i] > TMAX);
        return r;
    endfunction

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(string tag);
        check(tag, "pins", {29'd0, sd_ras_n, sd_cas_n, sd_we_n}, {29'd0, m_pins});
        check(tag, "ba", {30'd0, sd_ba}, {30'd0, m_ba});
        check(tag, "addr", {20'd0, sd_addr}, {20'd0, m_addr});
        check(tag, "error", {31'd0, req_error}, {31'd0, m_err});
        check(tag, "bank_active", {28'd0, bank_active}, {28'd0, m_open});
        check(tag, "tras_violation", {28'd0, tras_violation}, {28'd0, m_viol()});
    endtask

    task automatic model_edge(bit v, bit [1:0] op, bit [1:0] b, bit [11:0] a, bit ap);
        bit ok;
        ok = m_legal(v, op, b);
        m_pins = 3'b111; m_ba = '0; m_addr = '0; m_err = v && !ok;
        for (int i = 0; i < 4; i++)
            if (m_open[i] && m_cnt[i] < TMAX + 1) m_cnt[i]++;
        if (ok) begin
            case (op)
                2'b00: begin m_pins = 3'b011; m_ba = b; m_addr = a; m_open[b] = 1; m_cnt[b] = 0; end
                2'b01: begin
                    m_pins = 3'b100; m_ba = b; m_addr = {1'b0, ap, 1'b0, a[8:0]};
                    if (ap) begin m_open[b] = 0; m_cnt[b] = 0; end
                end
                2'b10: begin m_pins = 3'b010; m_ba = b; m_open[b] = 0; m_cnt[b] = 0; end
                default: begin
                    m_pins = 3'b010; m_addr = 12'h400;
                    for (int i = 0; i < 4; i++) begin m_open[i] = 0; m_cnt[i] = 0; end
                end
            endcase
        end
    endtask

    task automatic step(string tag, bit v, bit [1:0] op, bit [1:0] b, bit [11:0] a, bit ap);
        req_valid = v; req_op = op; req_bank = b; req_addr = a; req_autopre = ap;
        #1;
        check(tag, "req_ready", {31'd0, req_ready}, {31'd0, m_legal(v, op, b)});
        @(posedge clk);
        model_edge(v, op, b, a, ap);
        @(negedge clk);
        compare_all(tag);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        bit [15:0] lfsr;
        m_open = '0; m_pins = 3'b111; m_ba = '0; m_addr = '0; m_err = 0;
        for (int i = 0; i < 4; i++) m_cnt[i] = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        compare_all("R1");
        step("R9", 0, 2'b01, 2'd2, 12'hFFF, 1);
        step("R9", 0, 2'b00, 2'd1, 12'h123, 0);
        step("R2", 1, 2'b00, 2'd1, 12'hABC, 0);
        step("R7", 1, 2'b00, 2'd1, 12'h555, 0);
        step("R3", 1, 2'b01, 2'd1, 12'hFF5, 0);
        step("R6", 1, 2'b01, 2'd2, 12'h0AA, 0);
        step("R6", 1, 2'b01, 2'd2, 12'h0AA, 1);
        step("R10", 1, 2'b01, 2'd1, 12'h1F0, 1);
        step("R6", 1, 2'b01, 2'd1, 12'h001, 0);
        step("R2", 1, 2'b00, 2'd0, 12'h7FF, 0);
        step("R2", 1, 2'b00, 2'd3, 12'h800, 0);
        step("R4", 1, 2'b10, 2'd0, 12'hFFF, 1);
        step("R4", 1, 2'b10, 2'd2, 12'h000, 0);
        step("R5", 1, 2'b11, 2'd2, 12'hFFF, 0);
        step("R2", 1, 2'b00, 2'd2, 12'h321, 0);
        for (int i = 0; i < TMAX + 4; i++) step("R11", 0, 2'b00, 2'd0, 12'h000, 0);
        step("R12", 1, 2'b10, 2'd2, 12'h000, 0);
        step("R2", 1, 2'b00, 2'd0, 12'h010, 0);
        step("R2", 1, 2'b00, 2'd3, 12'h020, 0);
        for (int i = 0; i < TMAX + 2; i++) step("R11", 0, 2'b00, 2'd0, 12'h000, 0);
        step("R12", 1, 2'b11, 2'd1, 12'h000, 0);
        step("R2", 1, 2'b00, 2'd1, 12'h040, 0);
        for (int i = 0; i < TMAX + 2; i++) step("R11", 0, 2'b00, 2'd0, 12'h000, 0);
        step("R12", 1, 2'b01, 2'd1, 12'h003, 1);
        lfsr = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step("R8", lfsr[0] | lfsr[1], lfsr[3:2], lfsr[5:4], lfsr[15:4],
                 lfsr[6]);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule